// File: doc/BRIEF.md
# ATA Command Word Sequencer

This block takes 16-bit command words from a command queue through a valid/ready handshake. It decodes each word into one of four operations: a device register read, a device register write, a multi-transfer data read or write, or a device selection update. Register and data operations are passed to a PIO cycle engine as requests, one at a time. The engine acknowledges each completed bus cycle with a one-cycle pulse.

The sequencer keeps two pieces of state that later commands use: the selected device and the unit of the data count. The count unit is either single transfers or groups of eight. During a data command it counts the requests still to be issued. It also keeps a 14-bit counter of completed transfers. It reports a busy flag, a sticky flag for words that match no known format, and a flag for an operation that was cut short by the abort input.

Top module: `ata_cmd_seq`

## Requirements
- R1: After reset the block reports master selected (`devSel`=0), byte counting (`blockMode`=0), not busy, `cmdReady`=1, `reqValid`=0, `xferCount`=0, and both `termErr` and `illegalCmd` clear.
- R2: A word with bits 15:13 = 3'b001 and bits 7:0 = 0 is a register read. It issues one request with `reqKind`=0, `reqCs` taken from bits 12:11 and `reqAddr` taken from bits 10:8. If bits 7:0 are not zero, the word is illegal.
- R3: A word with bits 15:13 = 3'b101 is a register write. It issues one request with `reqKind`=1, the same CS and address fields as R2, and `reqData` equal to bits 7:0.
- R4: A word with bits 15:13 = 3'b010 is a data read (`reqKind`=2), and 3'b110 is a data write (`reqKind`=3). Bits 12:0 hold N. In byte mode, exactly N+1 requests are issued, each ended by one `reqAck`.
- R5: In block mode, a data command issues exactly (N+1)*8 requests.
- R6: A word whose bits 15:2 equal 14'h2740 sets `blockMode` from bit 1 and `devSel` from bit 0 (0 = master). It issues no request, and `reqDev` then follows `devSel`.
- R7: `xferCount` is cleared when a data command is accepted. It adds one for each `reqAck` during a data command and wraps at 14 bits. Register operations leave it unchanged.
- R8: While an operation runs, `pioBusy` is 1 and `cmdReady` is 0. The next word is accepted only after the last acknowledge or after an abort.
- R9: An `abort` while busy ends the operation at the next edge: `reqValid` drops and `termErr` is set. `termErr` stays set until the next register or data command is accepted. An `abort` while idle has no effect.
- R10: A word that matches no format is consumed and issues no request. It sets the sticky `illegalCmd` flag, which only reset clears, and it leaves `devSel` and `blockMode` unchanged.
- R11: If `abort` and `reqAck` arrive in the same cycle, the acknowledged transfer is still counted in `xferCount`, and the operation ends as terminated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word valid |
| cmdWord | input | 16 | Command word |
| cmdReady | output | 1 | Sequencer can take a word |
| abort | input | 1 | Terminate current operation |
| reqValid | output | 1 | Request to the PIO cycle engine |
| reqKind | output | 2 | 0 reg read, 1 reg write, 2 data read, 3 data write |
| reqCs | output | 2 | Chip select field |
| reqAddr | output | 3 | Device register address |
| reqData | output | 8 | Register write byte |
| reqDev | output | 1 | Device addressed by the request |
| reqAck | input | 1 | Engine finished one cycle |
| devSel | output | 1 | Selected device (0 master, 1 slave) |
| blockMode | output | 1 | Count unit is eight transfers |
| pioBusy | output | 1 | Operation in progress |
| xferCount | output | 14 | Completed data transfers |
| termErr | output | 1 | Last operation was terminated |
| illegalCmd | output | 1 | Sticky illegal-word flag |

## Verification
Two events can land on the same edge: the engine's acknowledge of a data beat and a terminate request. Both change the transfer counter and the busy state. The bench raises `abort` and `reqAck` together in the middle of a data command. It then judges that the beat was counted, that `termErr` is set, and that the block went idle with no further request. It also sends an abort in the same cycle as the acknowledge of the final beat, where the busy state would have ended either way.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam int CMD_W   = 16;
  localparam int FIELD_W = 13;

  typedef enum logic [1:0] {
    KIND_REG_RD = 2'd0,
    KIND_REG_WR = 2'd1,
    KIND_DAT_RD = 2'd2,
    KIND_DAT_WR = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic     load;
    logic     setDev;
    logic     setIllegal;
    logic     beat;
    logic     setTerm;
    reqKind_e kind;
  } seqStrobes_t;
endpackage

// File: rtl/ata_seq_ctl.sv
module ata_seq_ctl
  import ata_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             abort,
  input  logic             reqAck,
  input  reqKind_e         kindQ,
  input  logic             lastBeat,
  output logic             cmdReady,
  output logic             busy,
  output seqStrobes_t      stb
);
  localparam logic [13:0] SETDEV_CODE = 14'h2740;

  logic accept, isRegRd, isRegWr, isData, isSetDev, legalOp, doneNow;

  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;

  always_comb begin
    isRegRd  = (cmdWord[15:13] == 3'b001) && (cmdWord[7:0] == 8'h00);
    isRegWr  = (cmdWord[15:13] == 3'b101);
    isData   = (cmdWord[14:13] == 2'b10);
    isSetDev = (cmdWord[15:2] == SETDEV_CODE);
    legalOp  = isRegRd || isRegWr || isData;
    stb.kind = isRegRd ? KIND_REG_RD :
               isRegWr ? KIND_REG_WR :
               cmdWord[15] ? KIND_DAT_WR : KIND_DAT_RD;
    stb.load       = accept && legalOp;
    stb.setDev     = accept && isSetDev;
    stb.setIllegal = accept && !legalOp && !isSetDev;
    stb.beat       = busy && reqAck;
    stb.setTerm    = busy && abort;
  end

  assign doneNow = stb.beat &&
                   (kindQ == KIND_REG_RD || kindQ == KIND_REG_WR || lastBeat);

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else if (stb.load) busy <= 1'b1;
    else if (stb.setTerm || doneNow) busy <= 1'b0;
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> busy) else $error("load did not start");            // R8
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && abort) |=> (!busy && cmdReady)) else $error("abort ignored"); // R9
  AST_SETDEV_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setDev |=> !busy) else $error("set-device started request"); // R6
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setIllegal |=> !busy) else $error("illegal word started request"); // R10
endmodule

// File: rtl/ata_seq_dp.sv
module ata_seq_dp
  import ata_seq_pkg::*;
#(
  parameter int XCNT_W      = 14,
  parameter int BLOCK_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] cmdWord,
  input  seqStrobes_t      stb,
  output reqKind_e         kindQ,
  output logic             lastBeat,
  output logic [1:0]       csQ,
  output logic [2:0]       addrQ,
  output logic [7:0]       dataQ,
  output logic             devSel,
  output logic             blockMode,
  output logic [XCNT_W-1:0] xferCount,
  output logic             termErr,
  output logic             illegalCmd
);
  localparam int REM_W = FIELD_W + BLOCK_SHIFT + 1;

  logic [REM_W-1:0] remaining, loadCount;
  logic isDataKind;

  assign isDataKind = (kindQ == KIND_DAT_RD) || (kindQ == KIND_DAT_WR);
  assign lastBeat   = (remaining == REM_W'(1));

  always_comb begin
    loadCount = REM_W'(cmdWord[FIELD_W-1:0]) + REM_W'(1);
    if (blockMode) loadCount = loadCount << BLOCK_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ      <= KIND_REG_RD;
      csQ        <= '0;
      addrQ      <= '0;
      dataQ      <= '0;
      remaining  <= '0;
      devSel     <= 1'b0;
      blockMode  <= 1'b0;
      xferCount  <= '0;
      termErr    <= 1'b0;
      illegalCmd <= 1'b0;
    end else begin
      if (stb.load) begin
        kindQ     <= stb.kind;
        csQ       <= cmdWord[12:11];
        addrQ     <= cmdWord[10:8];
        dataQ     <= cmdWord[7:0];
        remaining <= loadCount;
        termErr   <= 1'b0;
        if (stb.kind == KIND_DAT_RD || stb.kind == KIND_DAT_WR) xferCount <= '0;
      end
      if (stb.beat && isDataKind) begin
        remaining <= remaining - REM_W'(1);
        xferCount <= xferCount + XCNT_W'(1);
      end
      if (stb.setTerm)    termErr    <= 1'b1;
      if (stb.setIllegal) illegalCmd <= 1'b1;
      if (stb.setDev) begin
        devSel    <= cmdWord[0];
        blockMode <= cmdWord[1];
      end
    end
  end

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |=> illegalCmd) else $error("illegal flag cleared");  // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beat && isDataKind) |=> xferCount == $past(xferCount) + XCNT_W'(1))
    else $error("transfer count step wrong");                         // R7
  AST_TERM_SET: assert property (@(posedge clk) disable iff (!rstN)
    stb.setTerm |=> termErr) else $error("terminate flag missing");   // R9
endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_seq_pkg::*;
#(
  parameter int XCNT_W      = 14,
  parameter int BLOCK_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [15:0]       cmdWord,
  output logic              cmdReady,
  input  logic              abort,
  output logic              reqValid,
  output logic [1:0]        reqKind,
  output logic [1:0]        reqCs,
  output logic [2:0]        reqAddr,
  output logic [7:0]        reqData,
  output logic              reqDev,
  input  logic              reqAck,
  output logic              devSel,
  output logic              blockMode,
  output logic              pioBusy,
  output logic [XCNT_W-1:0] xferCount,
  output logic              termErr,
  output logic              illegalCmd
);
  seqStrobes_t stb;
  reqKind_e    kindQ;
  logic        lastBeat, busy;

  ata_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .abort(abort), .reqAck(reqAck), .kindQ(kindQ), .lastBeat(lastBeat),
    .cmdReady(cmdReady), .busy(busy), .stb(stb)
  );

  ata_seq_dp #(.XCNT_W(XCNT_W), .BLOCK_SHIFT(BLOCK_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .stb(stb),
    .kindQ(kindQ), .lastBeat(lastBeat), .csQ(reqCs), .addrQ(reqAddr),
    .dataQ(reqData), .devSel(devSel), .blockMode(blockMode),
    .xferCount(xferCount), .termErr(termErr), .illegalCmd(illegalCmd)
  );

  assign reqValid = busy;
  assign pioBusy  = busy;
  assign reqKind  = kindQ;
  assign reqDev   = devSel;

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdReady && reqValid)) else $error("ready while requesting");  // R8
endmodule

// File: tb/sim_ata_cmd_seq.sv
module sim_ata_cmd_seq;
  logic clk = 0, rstN = 0, cmdValid = 0, abort = 0, reqAck = 0;
  logic [15:0] cmdWord = '0;
  logic cmdReady, reqValid, reqDev, devSel, blockMode, pioBusy, termErr, illegalCmd;
  logic [1:0] reqKind, reqCs;
  logic [2:0] reqAddr;
  logic [7:0] reqData;
  logic [13:0] xferCount;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ata_cmd_seq u0 (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendCmd(logic [15:0] w);
    @(negedge clk); cmdValid = 1; cmdWord = w;
    @(negedge clk); cmdValid = 0; cmdWord = '0;
  endtask

  // acks every request until reqValid drops; returns the beat count
  task automatic serve(output int n);
    n = 0;
    while (reqValid && n < 70000) begin
      reqAck = 1; @(negedge clk); reqAck = 0; n++;
    end
  endtask

  task automatic testReset;
    check("R1 devSel", devSel, 0); check("R1 blockMode", blockMode, 0);
    check("R1 busy", pioBusy, 0); check("R1 ready", cmdReady, 1);
    check("R1 req", reqValid, 0); check("R1 count", xferCount, 0);
    check("R1 flags", {termErr, illegalCmd}, 0);
  endtask

  task automatic testRegRead;
    int n;
    sendCmd(16'h2000 | (16'd2 << 11) | (16'd5 << 8));
    check("R2 req", reqValid, 1); check("R2 kind", reqKind, 0);
    check("R2 cs", reqCs, 2); check("R2 addr", reqAddr, 5);
    check("R8 notready", cmdReady, 0); check("R8 busy", pioBusy, 1);
    serve(n); check("R2 one beat", n, 1); check("R8 ready", cmdReady, 1);
  endtask

  task automatic testRegWrite;
    int n;
    sendCmd(16'hA000 | (16'd1 << 11) | (16'd7 << 8) | 16'h00EC);
    check("R3 kind", reqKind, 1); check("R3 cs", reqCs, 1);
    check("R3 addr", reqAddr, 7); check("R3 data", reqData, 8'hEC);
    serve(n); check("R3 one beat", n, 1);
  endtask

  task automatic testDataByte;
    int n;
    sendCmd(16'h4000 | 16'd4);
    check("R4 kind rd", reqKind, 2); check("R7 cleared", xferCount, 0);
    serve(n); check("R4 beats", n, 5); check("R7 count", xferCount, 5);
    sendCmd(16'hC000);
    check("R4 kind wr", reqKind, 3);
    serve(n); check("R4 single", n, 1); check("R7 count1", xferCount, 1);
    sendCmd(16'h2000);
    serve(n); check("R7 reg keeps", xferCount, 1);
  endtask

  task automatic testSetDev;
    sendCmd(16'h9D03);
    check("R6 noreq", reqValid, 0); check("R6 dev", devSel, 1);
    check("R6 block", blockMode, 1); check("R6 reqDev", reqDev, 1);
  endtask

  task automatic testBlock;
    int n;
    sendCmd(16'h4000 | 16'd1);
    serve(n); check("R5 beats", n, 16); check("R5 count", xferCount, 16);
    sendCmd(16'hC000 | 16'd2047);
    serve(n); check("R5 big", n, 16384); check("R7 wrap", xferCount, 0);
    sendCmd(16'h9D00);
    check("R6 back", {devSel, blockMode}, 0);
  endtask

  task automatic testAbort;
    int n;
    @(negedge clk); abort = 1; @(negedge clk); abort = 0;
    check("R9 idle abort", {termErr, pioBusy}, 0);
    sendCmd(16'h4000 | 16'd9);
    repeat (3) begin reqAck = 1; @(negedge clk); reqAck = 0; end
    abort = 1; @(negedge clk); abort = 0;
    check("R9 req", reqValid, 0); check("R9 term", termErr, 1);
    check("R9 count", xferCount, 3); check("R9 ready", cmdReady, 1);
    @(negedge clk); check("R9 stays", termErr, 1);
    sendCmd(16'h4000 | 16'd4);
    check("R9 cleared", termErr, 0);
    reqAck = 1; @(negedge clk);
    abort = 1; @(negedge clk); reqAck = 0; abort = 0;
    check("R11 count", xferCount, 2); check("R11 term", termErr, 1);
    check("R11 idle", reqValid, 0);
    sendCmd(16'h4000 | 16'd1);
    reqAck = 1; @(negedge clk);
    abort = 1; @(negedge clk); reqAck = 0; abort = 0;
    check("R11 last count", xferCount, 2); check("R11 last term", termErr, 1);
    check("R11 last idle", pioBusy, 0);
    sendCmd(16'h2000); serve(n);
    check("R9 reg clears", termErr, 0);
  endtask

  task automatic testIllegal;
    sendCmd(16'h2001);
    check("R2 lowbyte illegal", illegalCmd, 1); check("R10 noreq", reqValid, 0);
    sendCmd(16'h9D07);
    check("R10 dev kept", {devSel, blockMode}, 0); check("R10 noreq2", reqValid, 0);
    sendCmd(16'h0000);
    check("R10 ready", cmdReady, 1);
    repeat (3) @(negedge clk);
    check("R10 sticky", illegalCmd, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk); rstN = 1; @(negedge clk);
        testReset; testRegRead; testRegWrite; testDataByte;
        testSetDev; testBlock; testAbort; testIllegal;
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule